// File: doc/BRIEF.md
# Indirect Per-Channel Register Access Controller

This block gives software a narrow window into a large set of per-channel monitor registers. Instead of mapping every channel register onto the management bus, it exposes four management registers: a channel selector, a register offset, a data word and a control/status word. Software loads the selector, the offset and (for a store) the data. It then writes a command bit, and the block performs a single access on an internal register port.

The channel number software writes is logical. A parameterised table turns it into a physical channel index before the access. Each access takes a fixed number of cycles, and busy is visible for that whole time. A load returns its value in the data register by the time busy drops. A request that names a channel or offset outside the configured range sets an error flag and performs no access. The per-channel registers are held in an internal array that a block RAM can implement, and each entry powers up with a value that encodes its own physical location.

Top module: `chan_reg_access`

## Requirements
- R1: After reset the channel, offset, data and control/status registers all read 0, busy and error are low, and the management read data output is 0.
- R2: Address 0x10 holds a 10-bit channel number in bits [9:0], address 0x13 holds a 6-bit offset in bits [5:0] and address 0x14 holds 16-bit data in bits [15:0]. All other bits read 0. Any other address reads 0 and ignores writes.
- R3: Address 0x12 reads error in bit 9, busy in bit 8 and 0 in every other bit. This includes the two trigger bits (bit 1 = load, bit 0 = store), which always read back as 0.
- R4: Writing 0x12 with bit 1 set and bit 0 clear starts a load. Writing with bit 0 set starts a store, even when bit 1 is also set. Busy rises at the clock edge that samples the command write and stays high for exactly ACC_LAT cycles (default 4).
- R5: A store writes the data register into the selected register of the selected physical channel. A load copies that register into the data register at the edge where busy falls.
- R6: With the default map the physical channel is NUM_CHAN-1 minus the logical channel (default NUM_CHAN = 8). A parameter selects the identity map instead.
- R7: Before any store, the register at physical channel p and offset o holds 16'hC000 | (p << 6) | o.
- R8: A command naming a channel of NUM_CHAN or more, or an offset of NUM_REGS or more (default 48), sets error at the sampling edge. Busy stays low, no register is accessed and the data register keeps its value.
- R9: Error is cleared when the next valid command is accepted, at the same edge where busy rises. A write to 0x12 with both trigger bits clear leaves error unchanged.
- R10: While busy is high, including the edge at which it falls, command triggers are ignored and writes to the channel, offset and data registers are ignored.
- R11: The management read data output is registered. It takes the addressed value at the edge that samples a read strobe and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_addr | input | 7 | Management word address |
| mgmt_wr | input | 1 | Management write strobe |
| mgmt_rd | input | 1 | Management read strobe |
| mgmt_wdata | input | 32 | Management write data |
| mgmt_rdata | output | 32 | Registered management read data |

## Verification
Software can write to the management registers in the very cycle where an access completes. At that edge the block both drops busy and, for a load, overwrites the data register. The bench provokes this by timing a write to the data register so that it is sampled on the final busy edge, with the offset, channel and a store trigger written on the edges just before it. It then judges the outcome through the management port: the data register must hold the loaded value rather than the software write, the channel and offset must be unchanged, and busy must already be low one cycle later, which shows that no second access was started.

// File: rtl/car_pkg.sv
package car_pkg;
  localparam int MGMT_AW = 7;
  localparam int MGMT_DW = 32;
  localparam int CHAN_W  = 10;
  localparam int OFFS_W  = 6;
  localparam int DATA_W  = 16;

  localparam logic [MGMT_AW-1:0] ADDR_CHAN = 7'h10;
  localparam logic [MGMT_AW-1:0] ADDR_CTRL = 7'h12;
  localparam logic [MGMT_AW-1:0] ADDR_OFFS = 7'h13;
  localparam logic [MGMT_AW-1:0] ADDR_DATA = 7'h14;

  localparam int BIT_ERR  = 9;
  localparam int BIT_BUSY = 8;
  localparam int BIT_LOAD = 1;
  localparam int BIT_STOR = 0;

  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } op_e;
endpackage

// File: rtl/car_chan_map.sv
module car_chan_map #(
  parameter int NUM_CHAN    = 8,
  parameter int MAP_REVERSE = 1,
  parameter int PHYS_W      = 3
) (
  input  logic [PHYS_W-1:0] logical_idx,
  output logic [PHYS_W-1:0] phys_idx
);
  localparam int TBL_N = 1 << PHYS_W;

  logic [PHYS_W-1:0] tbl [TBL_N];

  generate
    for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
      if (g >= NUM_CHAN) begin : g_pad
        assign tbl[g] = '0;
      end else if (MAP_REVERSE != 0) begin : g_rev
        assign tbl[g] = PHYS_W'(NUM_CHAN - 1 - g);
      end else begin : g_id
        assign tbl[g] = PHYS_W'(g);
      end
    end
  endgenerate

  assign phys_idx = tbl[logical_idx];
endmodule

// File: rtl/car_reg_array.sv
module car_reg_array #(
  parameter int PHYS_W = 3,
  parameter int OFFS_W = 6,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [PHYS_W+OFFS_W-1:0] addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata
);
  localparam int AW    = PHYS_W + OFFS_W;
  localparam int DEPTH = 1 << AW;
  localparam logic [DATA_W-1:0] INIT_TAG = DATA_W'(16'hC000);

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = INIT_TAG | DATA_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
    rdata <= mem[addr];
  end
endmodule

// File: rtl/car_access_seq.sv
module car_access_seq
  import car_pkg::*;
#(
  parameter int ACC_LAT = 4,
  parameter int AW      = 9,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  op_e               start_op,
  input  logic [AW-1:0]     start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  output logic              busy,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              rd_load
);
  localparam int CNT_W = (ACC_LAT > 2) ? $clog2(ACC_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(ACC_LAT - 1);

  logic [CNT_W-1:0]  cnt_q;
  op_e               op_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              last_cyc;

  initial begin
    if (ACC_LAT < 2) $error("ACC_LAT must be at least 2");
  end

  assign last_cyc = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt_q   <= '0;
      op_q    <= OP_LOAD;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      cnt_q   <= CNT_TOP;
      op_q    <= start_op;
      addr_q  <= start_addr;
      wdata_q <= start_wdata;
    end else if (busy) begin
      if (cnt_q == '0) begin
        busy <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign mem_we    = last_cyc && (op_q == OP_STORE);
  assign rd_load   = last_cyc && (op_q == OP_LOAD);

  assert_start_idle_R10: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  assert_busy_after_start_R4: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  assert_busy_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_q != '0) |=> busy);

  assert_busy_drops_R4: assert property (@(posedge clk) disable iff (rst)
    last_cyc |=> !busy);
endmodule

// File: rtl/car_csr.sv
module car_csr
  import car_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int NUM_REGS = 48
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [MGMT_AW-1:0] mgmt_addr,
  input  logic               mgmt_wr,
  input  logic               mgmt_rd,
  input  logic [MGMT_DW-1:0] mgmt_wdata,
  output logic [MGMT_DW-1:0] mgmt_rdata,
  input  logic               busy,
  input  logic               rd_load,
  input  logic [DATA_W-1:0]  rd_data,
  output logic               start,
  output op_e                start_op,
  output logic [CHAN_W-1:0]  chan_q,
  output logic [OFFS_W-1:0]  offs_q,
  output logic [DATA_W-1:0]  data_q
);
  localparam logic [CHAN_W-1:0] CHAN_LIM = CHAN_W'(NUM_CHAN);
  localparam logic [OFFS_W:0]   OFFS_LIM = (OFFS_W+1)'(NUM_REGS);

  logic err_q;
  logic wr_open;
  logic cmd_hit;
  logic req_ok;
  logic bad;

  assign wr_open = mgmt_wr && !busy;
  assign cmd_hit = wr_open && (mgmt_addr == ADDR_CTRL) &&
                   (mgmt_wdata[BIT_LOAD] || mgmt_wdata[BIT_STOR]);
  assign req_ok  = (chan_q < CHAN_LIM) && ({1'b0, offs_q} < OFFS_LIM);
  assign start   = cmd_hit && req_ok;
  assign bad     = cmd_hit && !req_ok;
  assign start_op = mgmt_wdata[BIT_STOR] ? OP_STORE : OP_LOAD;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q <= '0;
      offs_q <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_open && mgmt_addr == ADDR_CHAN) chan_q <= mgmt_wdata[CHAN_W-1:0];
      if (wr_open && mgmt_addr == ADDR_OFFS) offs_q <= mgmt_wdata[OFFS_W-1:0];
      if (rd_load) begin
        data_q <= rd_data;
      end else if (wr_open && mgmt_addr == ADDR_DATA) begin
        data_q <= mgmt_wdata[DATA_W-1:0];
      end
      if (bad) begin
        err_q <= 1'b1;
      end else if (start) begin
        err_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mgmt_rdata <= '0;
    end else if (mgmt_rd) begin
      mgmt_rdata <= '0;
      case (mgmt_addr)
        ADDR_CHAN: mgmt_rdata[CHAN_W-1:0] <= chan_q;
        ADDR_OFFS: mgmt_rdata[OFFS_W-1:0] <= offs_q;
        ADDR_DATA: mgmt_rdata[DATA_W-1:0] <= data_q;
        ADDR_CTRL: begin
          mgmt_rdata[BIT_ERR]  <= err_q;
          mgmt_rdata[BIT_BUSY] <= busy;
        end
        default: ;
      endcase
    end
  end

  assert_bad_sets_err_R8: assert property (@(posedge clk) disable iff (rst)
    bad |=> (err_q && !busy));

  assert_start_clears_err_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> (!err_q && busy));

  assert_chan_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(chan_q) && $stable(offs_q)));

  assert_data_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_load) |=> $stable(data_q));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !mgmt_rd |=> $stable(mgmt_rdata));
endmodule

// File: rtl/chan_reg_access.sv
module chan_reg_access
  import car_pkg::*;
#(
  parameter int NUM_CHAN    = 8,
  parameter int NUM_REGS    = 48,
  parameter int ACC_LAT     = 4,
  parameter int MAP_REVERSE = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [MGMT_AW-1:0] mgmt_addr,
  input  logic               mgmt_wr,
  input  logic               mgmt_rd,
  input  logic [MGMT_DW-1:0] mgmt_wdata,
  output logic [MGMT_DW-1:0] mgmt_rdata
);
  localparam int PHYS_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;
  localparam int MEM_AW = PHYS_W + OFFS_W;

  logic              busy;
  logic              rd_load;
  logic              start;
  op_e               start_op;
  logic [CHAN_W-1:0] chan_q;
  logic [OFFS_W-1:0] offs_q;
  logic [DATA_W-1:0] data_q;
  logic [PHYS_W-1:0] phys_idx;
  logic              mem_we;
  logic [MEM_AW-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;

  car_csr #(
    .NUM_CHAN (NUM_CHAN),
    .NUM_REGS (NUM_REGS)
  ) u_csr (
    .clk        (clk),
    .rst        (rst),
    .mgmt_addr  (mgmt_addr),
    .mgmt_wr    (mgmt_wr),
    .mgmt_rd    (mgmt_rd),
    .mgmt_wdata (mgmt_wdata),
    .mgmt_rdata (mgmt_rdata),
    .busy       (busy),
    .rd_load    (rd_load),
    .rd_data    (mem_rdata),
    .start      (start),
    .start_op   (start_op),
    .chan_q     (chan_q),
    .offs_q     (offs_q),
    .data_q     (data_q)
  );

  car_chan_map #(
    .NUM_CHAN    (NUM_CHAN),
    .MAP_REVERSE (MAP_REVERSE),
    .PHYS_W      (PHYS_W)
  ) u_map (
    .logical_idx (chan_q[PHYS_W-1:0]),
    .phys_idx    (phys_idx)
  );

  car_access_seq #(
    .ACC_LAT (ACC_LAT),
    .AW      (MEM_AW),
    .DATA_W  (DATA_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .start_op    (start_op),
    .start_addr  ({phys_idx, offs_q}),
    .start_wdata (data_q),
    .busy        (busy),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .rd_load     (rd_load)
  );

  car_reg_array #(
    .PHYS_W (PHYS_W),
    .OFFS_W (OFFS_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  assert_store_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[OFFS_W-1:0] < OFFS_W'(NUM_REGS)));
endmodule

// File: tb/chan_reg_access_bench.sv
`timescale 1ns/1ps
module chan_reg_access_bench;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  mgmt_addr = '0;
  logic        mgmt_wr = 1'b0;
  logic        mgmt_rd = 1'b0;
  logic [31:0] mgmt_wdata = '0;
  logic [31:0] mgmt_rdata;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  chan_reg_access u_chan_reg_access (
    .clk        (clk),
    .rst        (rst),
    .mgmt_addr  (mgmt_addr),
    .mgmt_wr    (mgmt_wr),
    .mgmt_rd    (mgmt_rd),
    .mgmt_wdata (mgmt_wdata),
    .mgmt_rdata (mgmt_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; strobe sampled at the next posedge; returns at the following negedge.
  task automatic mwrite(input logic [6:0] a, input logic [31:0] d);
    mgmt_wr = 1'b1; mgmt_addr = a; mgmt_wdata = d;
    @(negedge clk);
    mgmt_wr = 1'b0;
  endtask

  task automatic mread(input logic [6:0] a, input logic [31:0] exp, input string req);
    mgmt_rd = 1'b1; mgmt_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    mgmt_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // Monitor: pops the expected item for each sampled read strobe.
  initial begin
    forever begin
      @(posedge clk);
      if (!rst && mgmt_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check("scoreboard-empty", 32'h1, 32'h0);
        end else begin
          check(tag_q.pop_front(), mgmt_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    check("R1 rdata", mgmt_rdata, 32'h0);
    mread(7'h10, 32'h0, "R1 chan");
    mread(7'h12, 32'h0, "R1 ctrl");
    mread(7'h13, 32'h0, "R1 offs");
    mread(7'h14, 32'h0, "R1 data");

    // R2 field widths and undefined addresses
    mwrite(7'h10, 32'hFFFF_FFFF);
    mwrite(7'h13, 32'hFFFF_FFFF);
    mwrite(7'h14, 32'hFFFF_FFFF);
    mwrite(7'h11, 32'hFFFF_FFFF);
    mread(7'h10, 32'h3FF, "R2 chan");
    mread(7'h13, 32'h3F, "R2 offs");
    mread(7'h14, 32'hFFFF, "R2 data");
    mread(7'h11, 32'h0, "R2 undef");
    mread(7'h00, 32'h0, "R2 undef0");

    // R4/R7/R6 load from logical 2 -> physical 5, offset 5
    mwrite(7'h10, 32'd2);
    mwrite(7'h13, 32'd5);
    mwrite(7'h12, 32'h2);
    mread(7'h12, 32'h100, "R3 busy trig-zero");
    idle(LAT - 2);
    mread(7'h12, 32'h100, "R4 busy last cycle");
    mread(7'h12, 32'h0, "R4 busy dropped");
    mread(7'h14, 32'hC145, "R7 load init phys5");

    // R5 store then load back
    mwrite(7'h14, 32'h1234);
    mwrite(7'h12, 32'h1);
    idle(LAT);
    mwrite(7'h14, 32'h0);
    mwrite(7'h12, 32'h2);
    idle(LAT);
    mread(7'h14, 32'h1234, "R5 store/load");
    // R6 logical 5 -> physical 2
    mwrite(7'h10, 32'd5);
    mwrite(7'h12, 32'h2);
    idle(LAT);
    mread(7'h14, 32'hC085, "R6 map logical5");

    // R4 both trigger bits -> store
    mwrite(7'h14, 32'h5555);
    mwrite(7'h10, 32'd0);
    mwrite(7'h13, 32'd0);
    mwrite(7'h12, 32'h3);
    idle(LAT);
    mwrite(7'h14, 32'h0);
    mwrite(7'h12, 32'h2);
    idle(LAT);
    mread(7'h14, 32'h5555, "R4 both bits store");

    // R8 bad channel
    mwrite(7'h10, 32'd8);
    mwrite(7'h12, 32'h2);
    mread(7'h12, 32'h200, "R8 bad chan");
    mread(7'h14, 32'h5555, "R8 data kept");
    // R9 empty trigger leaves error, valid command clears it
    mwrite(7'h12, 32'h0);
    mread(7'h12, 32'h200, "R9 no-trigger keeps err");
    mwrite(7'h10, 32'd1);
    mwrite(7'h13, 32'd1);
    mwrite(7'h12, 32'h2);
    mread(7'h12, 32'h100, "R9 err cleared");
    idle(LAT);
    // R8 bad offset
    mwrite(7'h13, 32'd48);
    mwrite(7'h12, 32'h1);
    mread(7'h12, 32'h200, "R8 bad offs");
    mwrite(7'h13, 32'd1);
    mwrite(7'h12, 32'h2);
    idle(LAT);
    mread(7'h12, 32'h0, "R9 err cleared again");

    // R10 writes during busy, incl. the completing edge (logical1 -> phys6, offs1)
    mwrite(7'h12, 32'h2);
    mwrite(7'h10, 32'd3);
    mwrite(7'h13, 32'd9);
    mwrite(7'h12, 32'h1);
    mwrite(7'h14, 32'hBEEF);
    mread(7'h12, 32'h0, "R10 no restart");
    mread(7'h14, 32'hC181, "R10 data load wins");
    mread(7'h10, 32'd1, "R10 chan kept");
    mread(7'h13, 32'd1, "R10 offs kept");

    // R11 read data holds
    idle(3);
    check("R11 hold", mgmt_rdata, 32'd1);

    while (exp_q.size() != 0) @(negedge clk);
    idle(2);
    finish_run();
  end
endmodule